// File: doc/BRIEF.md
# External Interrupt Trigger Detector

This block turns raw external interrupt pins into one-cycle request-set strobes for a bank of request flags that sits downstream. Each of eight external sources has its own 2-bit trigger mode: active low, active high, rising edge or falling edge. The pins are first brought into the clock domain by a two-flop synchronizer. Each source then compares its synchronized sample against the sample from the cycle before and raises its set strobe when its selected condition holds.

The trigger modes are held in two byte-wide mode registers on a small register bus with a write strobe and a combinational read port. Byte 0 serves sources 0 to 3 and byte 1 serves sources 4 to 7. This block does no request clearing and no priority selection. In the level modes the strobe repeats for as long as the input stays active. When the input goes inactive, the strobe simply stops; the block never issues a clear.

Top module: `ext_trig_detect`

## Requirements
- R1: After reset every mode field reads 3, so every source triggers on a falling edge. Mode bytes 0 and 1 both read 0xFF and set_o is all zero.
- R2: Mode byte b at offset b (b = 0, 1) configures sources 4b to 4b+3. Source 4b+k uses bits 2k+1:2k of that byte. Encoding: 0 active low, 1 active high, 2 rising edge, 3 falling edge. A write takes effect on the clock edge that samples cfg_wr_i, and a read returns the stored byte.
- R3: Offsets 2 and 3 read as 0x00. Writes to them change no mode field.
- R4: A pin change reaches set_o after two clock edges. A pin raised before edge n gives a set strobe in the cycle after edge n+1, and not in the cycle before it.
- R5: In active-low mode, set_o[k] is high in every cycle in which the synchronized pin k is 0.
- R6: In active-high mode, set_o[k] is high in every cycle in which the synchronized pin k is 1. A return to 0 ends the strobe and produces nothing else.
- R7: In rising-edge mode, set_o[k] is high for exactly one cycle per 0-to-1 transition of the synchronized pin.
- R8: In falling-edge mode, set_o[k] is high for exactly one cycle per 1-to-0 transition of the synchronized pin.
- R9: The previous-sample state tracks the pin in every mode. Changing a mode while the pins are steady produces no edge strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Raw external interrupt pins, asynchronous |
| cfg_addr_i | input | 2 | Mode register byte offset |
| cfg_wr_i | input | 1 | Write strobe for the mode registers |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Read data for cfg_addr_i, combinational |
| set_o | output | 8 | Per-source request-set strobes |

## Verification
Every source is swept through all four modes under a pseudo-random pin pattern with four-cycle holds. A mixed-mode byte gives each source a different mode, which exposes a field that is placed at the wrong bit position or routed to the wrong source. A separate single-pin test pins down the two-edge latency; a design with one synchronizer stage too many or too few shifts the strobe by a cycle. The pins are then held steady while the modes change between edge and level encodings. A design that stops updating its previous sample outside edge mode, or compares against stale state, fires a spurious strobe there. Writes to the unmapped offsets are checked for no aliasing into the real mode bytes.

// File: rtl/ext_trig_pkg.sv
package ext_trig_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_mode_e;

  localparam int unsigned MODE_W        = 2;
  localparam int unsigned BYTE_W        = 8;
  localparam int unsigned SRC_PER_BYTE  = BYTE_W / MODE_W;
  localparam logic [1:0]  MODE_RST      = 2'd3;
endpackage

// File: rtl/ext_trig_sync.sv
module ext_trig_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= '0;
    else         chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ext_trig_mode_regs.sv
module ext_trig_mode_regs
  import ext_trig_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ADDR_W-1:0]               cfg_addr_i,
  input  logic                            cfg_wr_i,
  input  logic [BYTE_W-1:0]               cfg_wdata_i,
  output logic [BYTE_W-1:0]               cfg_rdata_o,
  output logic [NUM_SRC-1:0][MODE_W-1:0]  mode_o
);
  localparam int unsigned NUM_BYTES = NUM_SRC / SRC_PER_BYTE;

  logic [NUM_BYTES-1:0][BYTE_W-1:0] mode_q;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mode_q[b] <= {SRC_PER_BYTE{MODE_RST}};
      else if (cfg_wr_i && cfg_addr_i == ADDR_W'(b))
        mode_q[b] <= cfg_wdata_i;
    end

    assign mode_o[b*SRC_PER_BYTE +: SRC_PER_BYTE] = mode_q[b];

    // R2: a write lands in the addressed byte's sources only
    a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_wr_i && cfg_addr_i == ADDR_W'(b)) |=>
        (mode_o[b*SRC_PER_BYTE +: SRC_PER_BYTE] == $past(cfg_wdata_i)));
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int b = 0; b < NUM_BYTES; b++)
      if (cfg_addr_i == ADDR_W'(b)) cfg_rdata_o = mode_q[b];
  end

  // R3: unmapped writes leave every mode field alone
  a_r3_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && int'(cfg_addr_i) >= NUM_BYTES) |=> $stable(mode_o));
endmodule

// File: rtl/ext_trig_edge.sv
module ext_trig_edge
  import ext_trig_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_SRC-1:0]             sync_i,
  input  logic [NUM_SRC-1:0][MODE_W-1:0] mode_i,
  output logic [NUM_SRC-1:0]             set_o
);
  logic [NUM_SRC-1:0] prev_q;

  // tracks the pin in every mode so a mode switch sees no stale edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    always_comb begin
      unique case (trig_mode_e'(mode_i[k]))
        TRIG_LOW:  set_o[k] = ~sync_i[k];
        TRIG_HIGH: set_o[k] =  sync_i[k];
        TRIG_RISE: set_o[k] =  sync_i[k] & ~prev_q[k];
        default:   set_o[k] = ~sync_i[k] &  prev_q[k];
      endcase
    end

    // R7 R8: edge strobes never last two cycles under an unchanged mode
    a_r7_edge_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_o[k] && mode_i[k][1]) |=> !(set_o[k] && mode_i[k] == $past(mode_i[k])));
  end
endmodule

// File: rtl/ext_trig_detect.sv
module ext_trig_detect
  import ext_trig_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  pin_i,
  input  logic [ADDR_W-1:0]   cfg_addr_i,
  input  logic                cfg_wr_i,
  input  logic [BYTE_W-1:0]   cfg_wdata_i,
  output logic [BYTE_W-1:0]   cfg_rdata_o,
  output logic [NUM_SRC-1:0]  set_o
);
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned NUM_BYTES   = NUM_SRC / SRC_PER_BYTE;
  localparam int unsigned WARM        = SYNC_STAGES + 1;
  localparam int unsigned WARM_W      = $clog2(WARM + 1);

  logic [NUM_SRC-1:0]             sync_pin;
  logic [NUM_SRC-1:0][MODE_W-1:0] mode;

  ext_trig_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (sync_pin)
  );

  ext_trig_mode_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .mode_o      (mode)
  );

  ext_trig_edge #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_pin),
    .mode_i (mode),
    .set_o  (set_o)
  );

  // cycles since reset, for pin-referenced checks
  logic [WARM_W-1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        warm_q <= '0;
    else if (warm_q != WARM_W'(WARM))   warm_q <= warm_q + 1'b1;
  end
  logic warm;
  assign warm = (warm_q == WARM_W'(WARM));

  // R3: unmapped offsets read zero
  a_r3_unmapped_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cfg_addr_i) >= NUM_BYTES) |-> (cfg_rdata_o == '0));

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
    a_r5_low_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm && mode[k] == TRIG_LOW && !$past(pin_i[k], 2)) |-> set_o[k]);
    a_r6_high_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm && mode[k] == TRIG_HIGH) |-> (set_o[k] == $past(pin_i[k], 2)));
    a_r7_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm && mode[k] == TRIG_RISE) |->
        (set_o[k] == ($past(pin_i[k], 2) && !$past(pin_i[k], 3))));
    a_r8_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm && mode[k] == TRIG_FALL) |->
        (set_o[k] == (!$past(pin_i[k], 2) && $past(pin_i[k], 3))));
  end
endmodule

// File: tb/tb_ext_trig_detect.sv
module tb_ext_trig_detect;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [N-1:0] pin = '0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [N-1:0] set;

  int checks = 0;
  int errs = 0;
  logic [7:0] mbyte [2];
  logic [7:0] lfsr = 8'h5a;
  logic [N-1:0] d0, d1, d2;

  always #10 clk = ~clk;

  ext_trig_detect dut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .cfg_addr_i(addr),
    .cfg_wr_i(wr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .set_o(set)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (a < 2) mbyte[a] = d;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    chk(rdata == exp, req, rdata, exp);
  endtask

  function automatic int src_mode(input int k);
    return int'((mbyte[k/4] >> (2*(k%4))) & 8'h3);
  endfunction

  function automatic bit exp_bit(input int m, input bit cur, input bit old);
    case (m)
      0: return !cur;
      1: return cur;
      2: return cur && !old;
      default: return !cur && old;
    endcase
  endfunction

  function automatic string mode_req(input int m);
    case (m)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  // pseudo-random pins, held four cycles every other four
  task automatic sweep(input int cycles, input string tag);
    int v = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (v >= 3) begin
        logic [N-1:0] e;
        string req;
        for (int k = 0; k < N; k++) e[k] = exp_bit(src_mode(k), d1[k], d2[k]);
        req = (tag != "") ? tag : mode_req(src_mode(0));
        chk(set == e, req, set, e);
      end
      d2 = d1; d1 = d0;
      if (i[2]) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        d0 = lfsr;
      end
      pin = d0;
      v++;
    end
  endtask

  task automatic hold_quiet(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(set == '0, req, set, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    mbyte[0] = 8'hff; mbyte[1] = 8'hff;
    d0 = '0; d1 = '0; d2 = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    #1 chk(set == '0, "R1", set, 0);
    rd_chk(2'd0, 8'hff, "R1");
    rd_chk(2'd1, 8'hff, "R1");
    sweep(200, "R1");

    // R2 readback and field placement
    wr_mode(2'd0, 8'h1b); rd_chk(2'd0, 8'h1b, "R2");
    wr_mode(2'd1, 8'hc6); rd_chk(2'd1, 8'hc6, "R2");
    rd_chk(2'd0, 8'h1b, "R2");

    // R3 unmapped offsets
    wr_mode(2'd2, 8'h00); wr_mode(2'd3, 8'h55);
    rd_chk(2'd2, 8'h00, "R3"); rd_chk(2'd3, 8'h00, "R3");
    rd_chk(2'd0, 8'h1b, "R3"); rd_chk(2'd1, 8'hc6, "R3");

    // R4 latency: single pin rise, rising mode
    pin = '0; d0 = '0;
    wr_mode(2'd0, 8'haa); wr_mode(2'd1, 8'haa);
    repeat (3) @(negedge clk);
    pin[0] = 1'b1;
    @(negedge clk); chk(set == '0, "R4", set, 0);
    @(negedge clk); chk(set == 8'h01, "R4", set, 8'h01);
    @(negedge clk); chk(set == '0, "R4", set, 0);
    d0 = pin;

    // R5..R8 each mode on every source
    for (int m = 0; m < 4; m++) begin
      logic [7:0] b = {4{m[1:0]}};
      wr_mode(2'd0, b); wr_mode(2'd1, b);
      sweep(300, "");
    end

    // mixed modes per source (R2 field positions)
    wr_mode(2'd0, 8'he4); wr_mode(2'd1, 8'h4e);
    sweep(300, "R2");

    // R9 mode change with steady pins
    wr_mode(2'd0, 8'hff); wr_mode(2'd1, 8'hff);
    pin = 8'ha5; d0 = pin;
    repeat (4) @(negedge clk);
    wr_mode(2'd0, 8'haa); wr_mode(2'd1, 8'haa); hold_quiet(4, "R9");
    wr_mode(2'd0, 8'h55); wr_mode(2'd1, 8'h55);
    @(negedge clk); chk(set == 8'ha5, "R9", set, 8'ha5);
    wr_mode(2'd0, 8'hff); wr_mode(2'd1, 8'hff); hold_quiet(4, "R9");
    wr_mode(2'd0, 8'haa); wr_mode(2'd1, 8'haa); hold_quiet(4, "R9");

    // R6 level end produces nothing further
    wr_mode(2'd0, 8'h55); wr_mode(2'd1, 8'h55);
    pin = '0;
    repeat (2) @(negedge clk);
    hold_quiet(4, "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule